// File: doc/BRIEF.md
# DTMF Steering and Digit Register

This block qualifies the early-steering level from a DTMF tone detector with a digital two-sided guard and holds the resulting digit. A tone pair becomes a digit only after the early-steering input has been high for a programmable number of consecutive clock cycles. Once registered, the digit survives short drop-outs and ends only after early steering has been low for a second programmable number of consecutive cycles. The two guard lengths arrive as inputs in clock cycles, and a counter restarts whenever the level changes before its limit is reached.

On registration the row and column indices are translated to the standard 4-bit digit code and latched. The guard-time output rises at the same edge. A delayed-steering flag follows after a fixed settling delay, and it is visible as a status bit. When interrupt mode is enabled, an active-low interrupt line is pulled low from the moment the flag rises until software reads the status word or the digit ends.

Reads use a single-cycle strobe with a select. The read port never exerts back-pressure: every strobe is accepted. Exactly one cycle later the result appears with a one-cycle valid pulse, and the reader must take it in that cycle.

Top module: `dtmf_steer`

## Requirements
- R1: After reset the guard output and the delayed flag are low, the interrupt line is high, and the held code and the pending interrupt are zero.
- R2: A digit is registered at the clock edge where `est_i` has been sampled high on `tone_on_cyc_i` consecutive edges. Any low sample before that restarts the count, so a shorter burst registers nothing and leaves the held code unchanged.
- R3: At the registration edge the code for (`row_i`, `col_i`) is latched. The held code changes at no other time.
- R4: `gt_o` rises at the registration edge. While the digit is active it is high in each cycle after an edge where `est_i` was sampled high, and otherwise it is low.
- R5: `ds_flag_o` rises exactly SETTLE_CYC edges after the registration edge, provided the digit is still active then. It is status bit 0.
- R6: Inside an active digit, a low run of `est_i` shorter than `tone_off_cyc_i` samples neither ends the digit nor re-registers a code, even if the indices change.
- R7: The digit ends at the edge where `est_i` has been sampled low on `tone_off_cyc_i` consecutive edges. `ds_flag_o` falls at that edge.
- R8: The interrupt-pending bit (status bit 1) is set when the flag rises. It is cleared by a status read or by the end of the digit, and a set wins over a clear in the same cycle. `irq_n_o` is low only while interrupt mode is on and the bit is set.
- R9: The code map uses row 0..3 for 697/770/852/941 Hz and column 0..3 for 1209/1336/1477/1633 Hz. Digits 1..9 give 1..9, and 0 gives 1010. The key * (row 3, column 0) gives 1011 and # (row 3, column 2) gives 1100. Column 3 gives A=1101, B=1110, C=1111 and D=0000.
- R10: A guard length of 0 behaves as 1.
- R11: A strobe on `rd_i` returns the held code when `rd_sel_i`=0, or the status word {2'b00, pending, flag} when `rd_sel_i`=1. The result comes on `rd_data_o` one cycle later with `rd_valid_o` high for one cycle, and the status returned is the value before any clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| est_i | input | 1 | Early steering, high while a valid tone pair is detected |
| row_i | input | 2 | Low-group tone index |
| col_i | input | 2 | High-group tone index |
| tone_on_cyc_i | input | CNT_W | Tone-present guard length in cycles |
| tone_off_cyc_i | input | CNT_W | Tone-absent guard length in cycles |
| irq_en_i | input | 1 | Interrupt mode enable |
| rd_i | input | 1 | Read strobe |
| rd_sel_i | input | 1 | Read select: 0 code, 1 status |
| gt_o | output | 1 | Guard-time output |
| ds_flag_o | output | 1 | Delayed-steering flag |
| irq_n_o | output | 1 | Active-low interrupt |
| rd_data_o | output | 4 | Read data |
| rd_valid_o | output | 1 | Read data valid, one cycle |

## Verification
The bench builds the block with CNT_W=8 and SETTLE_CYC=3. The settling delay is therefore longer than one cycle, and the flag edge can be told apart from the guard edge. The short guard lengths (5 on, 4 off, and also 0) keep every burst, drop-out and digit end within a few cycles, so each edge can be checked exactly. All sixteen row and column pairs fit in one run.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

  localparam int CODE_W = 4;

  // Row is the low-group index, col the high-group index.
  function automatic logic [CODE_W-1:0] pair_to_code(input logic [1:0] row,
                                                     input logic [1:0] col);
    logic [CODE_W-1:0] r4, c4;
    r4 = {2'b00, row};
    c4 = {2'b00, col};
    if (col == 2'd3) begin
      return 4'd13 + r4;            // A..D, D wraps to 0
    end else if (row == 2'd3) begin
      case (col)
        2'd0:    return 4'd11;      // star
        2'd1:    return 4'd10;      // zero
        default: return 4'd12;      // hash
      endcase
    end
    return r4 * 4'd3 + c4 + 4'd1;   // 1..9
  endfunction

endpackage

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last  = (limit_i == '0) ? '0 : limit_i - 1'b1;
  assign hit_o = run_i & lvl_i & (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i || !lvl_i || hit_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dtmf_settle.sv
module dtmf_settle #(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic set_o,
  output logic flag_o
);
  localparam int SC_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SC_W-1:0] LAST = SC_W'(SETTLE_CYC - 1);

  logic            armed_q;
  logic [SC_W-1:0] sc_q;

  assign set_o = armed_q & ~flag_o & ~abort_i & (sc_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      flag_o  <= 1'b0;
      sc_q    <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      flag_o  <= 1'b0;
      sc_q    <= '0;
    end else if (abort_i) begin
      armed_q <= 1'b0;
      flag_o  <= 1'b0;
    end else if (set_o) begin
      flag_o  <= 1'b1;
    end else if (armed_q && !flag_o) begin
      sc_q    <= sc_q + 1'b1;
    end
  end
endmodule

// File: rtl/dtmf_irq_ctrl.sv
module dtmf_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic pend_o,
  output logic irq_n_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
    end else if (set_i) begin
      pend_o <= 1'b1;
    end else if (clr_i) begin
      pend_o <= 1'b0;
    end
  end

  assign irq_n_o = ~(en_i & pend_o);
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
  import dtmf_steer_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             est_i,
  input  logic [1:0]       row_i,
  input  logic [1:0]       col_i,
  input  logic [CNT_W-1:0] tone_on_cyc_i,
  input  logic [CNT_W-1:0] tone_off_cyc_i,
  input  logic             irq_en_i,
  input  logic             rd_i,
  input  logic             rd_sel_i,
  output logic             gt_o,
  output logic             ds_flag_o,
  output logic             irq_n_o,
  output logic [3:0]       rd_data_o,
  output logic             rd_valid_o
);
  logic              in_digit_q;
  logic [CODE_W-1:0] code_q;
  logic              reg_evt, end_evt, flag_set, pend;

  dtmf_guard_timer #(.CNT_W(CNT_W)) u_on_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(~in_digit_q), .lvl_i(est_i),
    .limit_i(tone_on_cyc_i), .hit_o(reg_evt)
  );

  dtmf_guard_timer #(.CNT_W(CNT_W)) u_off_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(in_digit_q), .lvl_i(~est_i),
    .limit_i(tone_off_cyc_i), .hit_o(end_evt)
  );

  dtmf_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .start_i(reg_evt), .abort_i(end_evt),
    .set_o(flag_set), .flag_o(ds_flag_o)
  );

  dtmf_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set),
    .clr_i(end_evt | (rd_i & rd_sel_i)), .en_i(irq_en_i),
    .pend_o(pend), .irq_n_o(irq_n_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_digit_q <= 1'b0;
      code_q     <= '0;
      gt_o       <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      if (reg_evt) begin
        in_digit_q <= 1'b1;
        code_q     <= pair_to_code(row_i, col_i);
      end else if (end_evt) begin
        in_digit_q <= 1'b0;
      end
      gt_o       <= (in_digit_q | reg_evt) & est_i;
      rd_valid_o <= rd_i;
      if (rd_i) begin
        rd_data_o <= rd_sel_i ? {2'b00, pend, ds_flag_o} : code_q;
      end
    end
  end
endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       est_i,
  input logic       gt_o,
  input logic       ds_flag_o,
  input logic       irq_n_o,
  input logic       rd_i,
  input logic       rd_valid_o,
  input logic       in_digit_q,
  input logic [3:0] code_q
);
  AST_GT_AFTER_EST: assert property (@(posedge clk) disable iff (!rst_n)
    gt_o |-> $past(est_i)); // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> ds_flag_o); // R8
  AST_FLAG_IN_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    ds_flag_o |-> in_digit_q); // R5
  AST_FLAG_RISE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_flag_o) |-> $past(in_digit_q)); // R5
  AST_CODE_ON_REG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $rose(in_digit_q)); // R3
  AST_END_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_digit_q) |-> !$past(est_i)); // R7
  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_i)); // R11
endmodule

bind dtmf_steer dtmf_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .est_i(est_i), .gt_o(gt_o),
  .ds_flag_o(ds_flag_o), .irq_n_o(irq_n_o), .rd_i(rd_i),
  .rd_valid_o(rd_valid_o), .in_digit_q(in_digit_q), .code_q(code_q)
);

// File: tb/dtmf_steer_tb_top.sv
module dtmf_steer_tb_top;
  localparam int CW = 8;
  localparam int ST = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, est, irq_en, rd, rd_sel;
  logic [1:0] row, col;
  logic [CW-1:0] ton, toff;
  logic gt, ds, irq_n, rvalid;
  logic [3:0] rdata;

  dtmf_steer #(.CNT_W(CW), .SETTLE_CYC(ST)) dut_i (
    .clk(clk), .rst_n(rst_n), .est_i(est), .row_i(row), .col_i(col),
    .tone_on_cyc_i(ton), .tone_off_cyc_i(toff), .irq_en_i(irq_en),
    .rd_i(rd), .rd_sel_i(rd_sel), .gt_o(gt), .ds_flag_o(ds),
    .irq_n_o(irq_n), .rd_data_o(rdata), .rd_valid_o(rvalid)
  );

  int n_chk = 0, n_fail = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_code(input int r, input int c);
    case ({r[1:0], c[1:0]})
      4'b0000: return 4'b0001; 4'b0001: return 4'b0010;
      4'b0010: return 4'b0011; 4'b0011: return 4'b1101;
      4'b0100: return 4'b0100; 4'b0101: return 4'b0101;
      4'b0110: return 4'b0110; 4'b0111: return 4'b1110;
      4'b1000: return 4'b0111; 4'b1001: return 4'b1000;
      4'b1010: return 4'b1001; 4'b1011: return 4'b1111;
      4'b1100: return 4'b1011; 4'b1101: return 4'b1010;
      4'b1110: return 4'b1100; default: return 4'b0000;
    endcase
  endfunction

  // driver: issue read, push expectation
  task automatic rd_req(input bit sel, input logic [3:0] exp, input string tag);
    @(negedge clk);
    rd = 1'b1; rd_sel = sel;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R11 unexpected rd_valid", 1, 0);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata == e, t, int'(rdata), int'(e));
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; est = 0; irq_en = 0; rd = 0; rd_sel = 0;
    row = 0; col = 0; ton = 5; toff = 4;
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    // R1 reset state
    chk(gt == 0, "R1 gt", gt, 0);
    chk(ds == 0, "R1 ds", ds, 0);
    chk(irq_n == 1, "R1 irq_n", irq_n, 1);
    rd_req(0, 4'h0, "R1 code after reset");
    rd_req(1, 4'h0, "R1 status after reset");

    // R2 short burst rejected
    row = 1; col = 1; est = 1;
    for (int i = 1; i < 5; i++) begin
      @(negedge clk);
      chk(gt == 0, "R2 short burst gt", gt, 0);
    end
    est = 0;
    wait_n(3);
    chk(ds == 0, "R2 short burst ds", ds, 0);
    rd_req(0, 4'h0, "R2 code unchanged after burst");

    // R2 restart: 3 high, 1 low, then 5 high
    est = 1;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk(gt == 0, "R2 before restart", gt, 0);
    end
    est = 0;
    @(negedge clk);
    est = 1;
    for (int i = 1; i <= 5 + ST + 1; i++) begin
      @(negedge clk);
      chk(gt == (i >= 5), "R2 R4 registration edge", gt, (i >= 5));
      chk(ds == (i >= 5 + ST), "R5 settle edge", ds, (i >= 5 + ST));
    end
    rd_req(0, ref_code(1, 1), "R3 latched code");

    // R6 drop-out shorter than tone_off, indices change meanwhile
    row = 3; col = 3; est = 0;
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      chk(ds == 1, "R6 flag held in drop-out", ds, 1);
      chk(gt == 0, "R4 gt low in drop-out", gt, 0);
    end
    est = 1;
    @(negedge clk);
    chk(gt == 1, "R4 gt back after drop-out", gt, 1);
    wait_n(6);
    chk(ds == 1, "R6 still same digit", ds, 1);
    rd_req(0, ref_code(1, 1), "R6 no re-register");

    // R7 digit end
    est = 0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      chk(ds == (i < 4), "R7 end edge", ds, (i < 4));
      chk(gt == 0, "R7 gt low", gt, 0);
    end

    // R8 interrupt cleared by status read
    irq_en = 1; row = 0; col = 2; est = 1;
    wait_n(5 + ST);
    chk(ds == 1, "R8 flag up", ds, 1);
    chk(irq_n == 0, "R8 irq asserted", irq_n, 0);
    rd_req(1, 4'b0011, "R8 R11 status with pending");
    chk(irq_n == 1, "R8 irq cleared by status read", irq_n, 1);
    chk(ds == 1, "R8 flag kept after read", ds, 1);
    rd_req(1, 4'b0001, "R8 status after clear");
    est = 0;
    wait_n(5);

    // R8 interrupt cleared by digit end
    est = 1;
    wait_n(5 + ST);
    chk(irq_n == 0, "R8 irq asserted again", irq_n, 0);
    est = 0;
    wait_n(5);
    chk(irq_n == 1, "R8 irq cleared by end", irq_n, 1);
    chk(ds == 0, "R7 flag cleared", ds, 0);

    // R8 interrupt mode off
    irq_en = 0; est = 1;
    wait_n(5 + ST);
    chk(ds == 1, "R8 flag up mode off", ds, 1);
    chk(irq_n == 1, "R8 irq stays high mode off", irq_n, 1);
    rd_req(1, 4'b0011, "R8 pending without mode");
    est = 0;
    wait_n(5);

    // R9 full code map
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        row = r[1:0]; col = c[1:0]; est = 1;
        wait_n(5);
        est = 0;
        rd_req(0, ref_code(r, c), $sformatf("R9 code row%0d col%0d", r, c));
        wait_n(4);
      end
    end

    // R10 zero guard lengths
    ton = 0; toff = 0; row = 2; col = 0; est = 1;
    for (int i = 1; i <= 1 + ST; i++) begin
      @(negedge clk);
      chk(gt == 1, "R10 one-cycle registration", gt, 1);
      chk(ds == (i >= 1 + ST), "R10 settle", ds, (i >= 1 + ST));
    end
    est = 0;
    @(negedge clk);
    chk(ds == 0, "R10 one-cycle end", ds, 0);
    rd_req(0, ref_code(2, 0), "R10 code");

    wait_n(2);
    chk(exp_q.size() == 0, "R11 all reads returned", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule